// File: doc/BRIEF.md
# Three-Output Stereo Mixing Matrix

The block derives three output channels from one stereo sample pair. Every output is a weighted sum of the left and right inputs, and each of the six weights is a programmable signed fractional coefficient. After reset, outputs 1 and 2 pass the left and right inputs through and output 3 carries a half-weighted mono sum of both, which suits a subwoofer feed in a 2.1 speaker arrangement. Filtering, volume and dynamics stages downstream are outside the block.

A sample pair is accepted with a one-cycle valid strobe when the block is idle. A single multiplier is shared across the six products, one product per clock. The three results appear together with a one-cycle valid pulse a fixed number of clocks later. The coefficients are written one at a time through a small write port. A write never disturbs a sample that is already being processed.

Top module: `mixm_top`

## Requirements
- R1: Each output equals floor(L*Ck1 / 2^23) + floor(R*Ck2 / 2^23), where Ck1 and Ck2 are that output's left and right coefficients in signed Q1.23. Each product is truncated toward minus infinity on its own, before the two are added.
- R2: After reset, output 1 uses left coefficient 0x7FFFFF and right coefficient 0x000000.
- R3: After reset, output 2 uses left coefficient 0x000000 and right coefficient 0x7FFFFF.
- R4: After reset, output 3 uses 0x400000 for both inputs, which gives (L+R)/2 within truncation.
- R5: A write with coef_we high stores coef_wdata into the coefficient selected by coef_sel = 2*(k-1) + j. Here k = 1..3 is the output and j = 0 selects left and j = 1 selects right.
- R6: A sum outside the 24-bit signed range saturates to 0x7FFFFF or 0x800000.
- R7: If in_valid is high at a clock edge while the block is idle, out_valid is high for exactly one cycle, starting at the sixth clock edge after the accepting edge. The three results are valid during that cycle and hold until the next result.
- R8: in_valid is ignored while a computation is in progress. It produces no extra out_valid pulse and does not change the result.
- R9: A coefficient write at or after the edge that accepts a sample takes effect only from the next accepted sample.
- R10: A write with coef_sel equal to 6 or 7 changes no coefficient.
- R11: During and right after reset, out_valid is low and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe for a new sample pair |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| coef_we | input | 1 | Coefficient write enable |
| coef_sel | input | 3 | Coefficient index, 2*(output-1)+input |
| coef_wdata | input | COEF_W | Coefficient value, signed Q1.23 |
| out_valid | output | 1 | One-cycle strobe for new results |
| out_ch1 | output | DATA_W | Mixed output 1 |
| out_ch2 | output | DATA_W | Mixed output 2 |
| out_ch3 | output | DATA_W | Mixed output 3 |

## Verification
For every sample, the results are due exactly six clock edges after the edge that accepts the strobe. The bench samples out_valid one time unit after the fifth edge, where it must be low, and again after the sixth, where it must be high. It compares all three outputs with its own model at the sixth edge. It then checks one edge later that the strobe has dropped. Inputs change only on falling edges. For the tests of ignored strobes and writes during a computation, the stimulus goes in at a known edge inside that six-edge window, so the effect must show on the current result or on the next one.

// File: rtl/mixm_pkg.sv
package mixm_pkg;
   localparam int unsigned N_OUT  = 3;
   localparam int unsigned N_IN   = 2;
   localparam int unsigned N_COEF = N_OUT * N_IN;

   typedef enum logic [1:0] {
      DEF_ZERO,
      DEF_UNITY,
      DEF_HALF
   } coef_def_e;

   // reset value of each coefficient slot, index = 2*output + input
   function automatic coef_def_e coef_default(input int unsigned idx);
      case (idx)
         0, 3:    return DEF_UNITY;
         4, 5:    return DEF_HALF;
         default: return DEF_ZERO;
      endcase
   endfunction
endpackage

// File: rtl/mixm_coef_bank.sv
module mixm_coef_bank
   import mixm_pkg::*;
#(
   parameter int unsigned COEF_W = 24,
   parameter int unsigned SEL_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [SEL_W-1:0]         sel,
   input  logic [COEF_W-1:0]        wdata,
   input  logic                     snap,
   output logic [N_COEF*COEF_W-1:0] work_flat
);
   localparam logic [COEF_W-1:0] UNITY_V = {1'b0, {(COEF_W-1){1'b1}}};
   localparam logic [COEF_W-1:0] HALF_V  = {2'b01, {(COEF_W-2){1'b0}}};

   logic [COEF_W-1:0]        live [N_COEF];
   logic [COEF_W-1:0]        work [N_COEF];
   logic [N_COEF*COEF_W-1:0] live_flat;

   for (genvar i = 0; i < N_COEF; i++) begin : g_slot
      localparam coef_def_e         DEF   = coef_default(i);
      localparam logic [COEF_W-1:0] RST_V = (DEF == DEF_UNITY) ? UNITY_V :
                                            (DEF == DEF_HALF)  ? HALF_V  : '0;

      always_ff @(posedge clk) begin
         if (!rst_n)
            live[i] <= RST_V;
         else if (we && (sel == SEL_W'(i)))
            live[i] <= wdata;
      end

      // working copy is frozen for the whole computation of one sample
      always_ff @(posedge clk) begin
         if (!rst_n)
            work[i] <= RST_V;
         else if (snap)
            work[i] <= live[i];
      end

      assign live_flat[i*COEF_W +: COEF_W] = live[i];
      assign work_flat[i*COEF_W +: COEF_W] = work[i];
   end

   p_frozen_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(work_flat));

   p_bad_sel_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (we && (int'(sel) >= N_COEF)) |=> $stable(live_flat));
endmodule

// File: rtl/mixm_seq.sv
module mixm_seq #(
   parameter int unsigned N_STEP = 6,
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              start,
   output logic              busy,
   output logic [STEP_W-1:0] step,
   output logic              out_valid
);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEP - 1);

   assign start = in_valid && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         step      <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (start) begin
            busy <= 1'b1;
            step <= '0;
         end else if (busy) begin
            if (step == LAST) begin
               busy      <= 1'b0;
               step      <= '0;
               out_valid <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
         end
      end
   end

   p_start_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && (step == '0)));

   p_done_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (step == LAST)) |=> (out_valid && !busy));

   p_pulse_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   p_step_range_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (step <= LAST));
endmodule

// File: rtl/mixm_mac.sv
module mixm_mac
   import mixm_pkg::*;
#(
   parameter int unsigned DATA_W        = 24,
   parameter int unsigned COEF_W        = 24,
   parameter int unsigned GUARD_W       = 2,
   parameter int unsigned STEP_W        = 3,
   parameter bit          ROUND_NEAREST = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      busy,
   input  logic [STEP_W-1:0]         step,
   input  logic [DATA_W-1:0]         in_left,
   input  logic [DATA_W-1:0]         in_right,
   input  logic [N_COEF*COEF_W-1:0]  coef_flat,
   output logic [N_OUT*DATA_W-1:0]   res_flat
);
   localparam int unsigned PROD_W = DATA_W + COEF_W;
   localparam int unsigned ACC_W  = DATA_W + GUARD_W;
   localparam int unsigned SHIFT  = COEF_W - 1;

   localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (DATA_W - 1));

   logic signed [DATA_W-1:0] smp_l, smp_r;
   logic signed [COEF_W-1:0] c_sel;
   logic signed [DATA_W-1:0] s_sel;
   logic signed [PROD_W-1:0] prod, prod_adj;
   logic signed [ACC_W-1:0]  scaled, acc, sum, clip;
   logic signed [DATA_W-1:0] res [N_OUT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_l <= '0;
         smp_r <= '0;
      end else if (start) begin
         smp_l <= in_left;
         smp_r <= in_right;
      end
   end

   // one shared multiplier; even steps take the left term, odd steps the right
   always_comb begin
      c_sel = coef_flat[int'(step)*COEF_W +: COEF_W];
      s_sel = step[0] ? smp_r : smp_l;
      prod  = PROD_W'(c_sel) * PROD_W'(s_sel);
   end

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (SHIFT - 1);
      assign prod_adj = prod + HALF_LSB;
   end else begin : g_trunc
      assign prod_adj = prod;
   end

   always_comb begin
      scaled = ACC_W'(prod_adj >>> SHIFT);
      sum    = acc + scaled;
      if (sum > MAXV)
         clip = MAXV;
      else if (sum < MINV)
         clip = MINV;
      else
         clip = sum;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc <= '0;
      else if (busy && !step[0])
         acc <= scaled;
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_res
      always_ff @(posedge clk) begin
         if (!rst_n)
            res[k] <= '0;
         else if (busy && (step == STEP_W'(2*k + 1)))
            res[k] <= DATA_W'(clip);
      end
      assign res_flat[k*DATA_W +: DATA_W] = res[k];
   end

   p_hold_smp_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(smp_l) && $stable(smp_r)));

   p_res_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(res_flat));
endmodule

// File: rtl/mixm_top.sv
module mixm_top
   import mixm_pkg::*;
#(
   parameter int unsigned DATA_W        = 24,
   parameter int unsigned COEF_W        = 24,
   parameter int unsigned GUARD_W       = 2,
   parameter bit          ROUND_NEAREST = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_left,
   input  logic signed [DATA_W-1:0] in_right,
   input  logic                     coef_we,
   input  logic [2:0]               coef_sel,
   input  logic [COEF_W-1:0]        coef_wdata,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_ch1,
   output logic signed [DATA_W-1:0] out_ch2,
   output logic signed [DATA_W-1:0] out_ch3
);
   localparam int unsigned N_STEP = N_COEF;
   localparam int unsigned STEP_W = $clog2(N_STEP);

   if (GUARD_W < 2) begin : g_chk_guard
      $error("GUARD_W must be at least 2");
   end
   if (COEF_W < 3) begin : g_chk_coef
      $error("COEF_W must be at least 3");
   end
   if (DATA_W < 2) begin : g_chk_data
      $error("DATA_W must be at least 2");
   end

   logic                     start, busy;
   logic [STEP_W-1:0]        step;
   logic [N_COEF*COEF_W-1:0] work_flat;
   logic [N_OUT*DATA_W-1:0]  res_flat;

   mixm_seq #(.N_STEP(N_STEP), .STEP_W(STEP_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .start    (start),
      .busy     (busy),
      .step     (step),
      .out_valid(out_valid)
   );

   mixm_coef_bank #(.COEF_W(COEF_W), .SEL_W(3)) u_coef (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (coef_we),
      .sel      (coef_sel),
      .wdata    (coef_wdata),
      .snap     (start),
      .work_flat(work_flat)
   );

   mixm_mac #(
      .DATA_W       (DATA_W),
      .COEF_W       (COEF_W),
      .GUARD_W      (GUARD_W),
      .STEP_W       (STEP_W),
      .ROUND_NEAREST(ROUND_NEAREST)
   ) u_mac (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .step     (step),
      .in_left  (in_left),
      .in_right (in_right),
      .coef_flat(work_flat),
      .res_flat (res_flat)
   );

   assign out_ch1 = res_flat[0*DATA_W +: DATA_W];
   assign out_ch2 = res_flat[1*DATA_W +: DATA_W];
   assign out_ch3 = res_flat[2*DATA_W +: DATA_W];

   p_busy_no_valid_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_valid) |=> busy || out_valid);
endmodule

// File: tb/mixm_top_tb.sv
module mixm_top_tb;
   localparam int CLK_PERIOD = 10;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [23:0] in_left = '0, in_right = '0;
   logic               coef_we = 1'b0;
   logic [2:0]         coef_sel = '0;
   logic [23:0]        coef_wdata = '0;
   logic               out_valid;
   logic signed [23:0] out_ch1, out_ch2, out_ch3;

   int errors = 0;
   int checks = 0;
   longint cm [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   mixm_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_left(in_left), .in_right(in_right),
      .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
      .out_valid(out_valid), .out_ch1(out_ch1), .out_ch2(out_ch2), .out_ch3(out_ch3)
   );

   function automatic longint mix(longint l, longint r, longint c1, longint c2);
      longint s = ((l * c1) >>> 23) + ((r * c2) >>> 23);
      if (s > 8388607)  s = 8388607;
      if (s < -8388608) s = -8388608;
      return s;
   endfunction

   function automatic longint sx(logic [23:0] v);
      return longint'(signed'(v));
   endfunction

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_coef(int sel, logic [23:0] val);
      @(negedge clk);
      coef_we = 1'b1; coef_sel = 3'(sel); coef_wdata = val;
      @(negedge clk);
      coef_we = 1'b0;
      if (sel < 6) cm[sel] = sx(val);
   endtask

   // drives one sample, returns one time unit after the sixth edge past acceptance
   task automatic send(logic signed [23:0] l, logic signed [23:0] r);
      @(negedge clk);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (5) @(posedge clk);
      #1 check("R7 early strobe", longint'(out_valid), 0);
      @(posedge clk);
      #1 check("R7 strobe due", longint'(out_valid), 1);
   endtask

   task automatic check_outs(string tag, longint l, longint r);
      check({tag, " ch1"}, longint'(out_ch1), mix(l, r, cm[0], cm[1]));
      check({tag, " ch2"}, longint'(out_ch2), mix(l, r, cm[2], cm[3]));
      check({tag, " ch3"}, longint'(out_ch3), mix(l, r, cm[4], cm[5]));
   endtask

   task automatic check_pulse_end();
      @(posedge clk);
      #1 check("R7 pulse width", longint'(out_valid), 0);
   endtask

   task automatic t_reset();
      check("R11 valid low", longint'(out_valid), 0);
      check("R11 ch1 zero", longint'(out_ch1), 0);
      check("R11 ch3 zero", longint'(out_ch3), 0);
   endtask

   task automatic t_defaults();
      send(24'sh123456, -24'sh200000);
      check("R2 ch1 pass left", longint'(out_ch1), mix(24'h123456, -24'sh200000, 8388607, 0));
      check("R3 ch2 pass right", longint'(out_ch2), mix(24'h123456, -24'sh200000, 0, 8388607));
      check("R4 ch3 half sum", longint'(out_ch3), mix(24'h123456, -24'sh200000, 4194304, 4194304));
      check_pulse_end();
   endtask

   task automatic t_program();
      write_coef(0, 24'h800000);
      write_coef(1, 24'h200000);
      write_coef(2, 24'h0FFFFF);
      write_coef(3, 24'hC00000);
      write_coef(4, 24'h7FFFFF);
      write_coef(5, 24'hFFFFFF);
      send(24'sh3ABCDE, -24'sh111111);
      check_outs("R1 R5 pattern A", 24'sh3ABCDE, -24'sh111111);
      check_pulse_end();
      send(-24'sh7FFFF1, 24'sh000003);
      check_outs("R1 pattern B", -24'sh7FFFF1, 24'sh000003);
      send(24'sh000001, -24'sh000001);
      check_outs("R1 floor C", 24'sh000001, -24'sh000001);
   endtask

   task automatic t_saturate();
      write_coef(0, 24'h7FFFFF);
      write_coef(1, 24'h7FFFFF);
      write_coef(2, 24'h800000);
      write_coef(3, 24'h800000);
      send(24'sh7FFFFF, 24'sh7FFFFF);
      check("R6 positive clip", longint'(out_ch1), 8388607);
      check("R6 negative clip", longint'(out_ch2), -8388608);
   endtask

   task automatic t_busy_ignore();
      int pulses = 0;
      @(negedge clk);
      in_valid = 1'b1; in_left = 24'sh050505; in_right = 24'sh0A0A0A;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      in_valid = 1'b1; in_left = -24'sh400000; in_right = 24'sh300000;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(posedge clk);
      #1 check("R8 strobe for first sample", longint'(out_valid), 1);
      check_outs("R8 first sample kept", 24'sh050505, 24'sh0A0A0A);
      for (int i = 0; i < 10; i++) begin
         @(posedge clk);
         #1 if (out_valid) pulses++;
      end
      check("R8 no extra strobe", pulses, 0);
   endtask

   task automatic t_write_during();
      longint old4 = cm[4];
      @(negedge clk);
      in_valid = 1'b1; in_left = 24'sh200000; in_right = 24'sh100000;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      coef_we = 1'b1; coef_sel = 3'd4; coef_wdata = 24'hE00000;
      @(negedge clk);
      coef_we = 1'b0;
      repeat (4) @(posedge clk);
      @(posedge clk);
      #1 check("R9 strobe", longint'(out_valid), 1);
      check("R9 current uses old", longint'(out_ch3), mix(24'sh200000, 24'sh100000, old4, cm[5]));
      cm[4] = sx(24'hE00000);
      send(24'sh200000, 24'sh100000);
      check("R9 next uses new", longint'(out_ch3), mix(24'sh200000, 24'sh100000, cm[4], cm[5]));
   endtask

   task automatic t_bad_sel();
      write_coef(6, 24'h123456);
      write_coef(7, 24'h654321);
      send(-24'sh0F0F0F, 24'sh2468AC);
      check_outs("R10 bad index ignored", -24'sh0F0F0F, 24'sh2468AC);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R7 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      cm[0] = 8388607; cm[1] = 0;
      cm[2] = 0;       cm[3] = 8388607;
      cm[4] = 4194304; cm[5] = 4194304;
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      #1 t_reset();
      t_defaults();
      t_program();
      t_saturate();
      t_busy_ignore();
      t_write_during();
      t_bad_sel();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule